// File: doc/BRIEF.md
# Secondary Interrupt Controller with Direct Routing

This block collects 32 level-sensitive interrupt sources and presents them to a primary interrupt controller. Each clock it registers the level of every source. Software keeps an enable mask. The AND of the raw levels and the mask is reduced by OR onto one aggregate line, output line 31. A band of sources, 21 through 30, can also be routed one for one to the output line of the same number. The primary controller then sees those sources directly, with no masking.

All control goes through a small register bus with a 4 KB window. The word index is the byte address shifted right by two. Set and clear writes touch only the bits written as 1. Separate set and clear writes act on bit 0 of the enable mask as a software interrupt.

Top module: `sic_pass_ctrl`

## Requirements
- R1: While reset is asserted (active-low, asynchronous), the raw-level, enable and routing registers clear and every output line is low. After release, reads of index 0, 1, 2 and 8 return 0.
- R2: Each source is registered every clock. A read of index 1 returns the registered raw levels one cycle after the inputs change.
- R3: A write to index 2 ORs the data into the enable mask. A write to index 3 clears the mask bits written as 1. A read of index 2 returns the mask.
- R4: A nonzero write to index 4 sets mask bit 0, and a nonzero write to index 5 clears it. Writing zero to either index leaves the mask unchanged. A read of index 4 returns raw bit 0 in bit 0.
- R5: A read of index 0 returns raw levels AND enable mask.
- R6: Output line 31 is high exactly when raw levels AND enable mask is nonzero.
- R7: A write to index 8 sets routing bits from the data ANDed with 0x7FE00000, so only bits 21 to 30 can be set. A write to index 9 clears the routing bits written as 1, with no filter. A read of index 8 returns the routing bits.
- R8: While routing bit n is set, output line n equals registered raw source n, whatever the enable mask holds.
- R9: When routing bit n is clear, output line n (21 to 30) holds the last value it drove. It is 0 if the line has never been routed.
- R10: Output lines 0 to 20 are always low.
- R11: Reads of any index other than 0, 1, 2, 4 and 8 return 0. Writes to any index other than 2, 3, 4, 5, 8 and 9 change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| src_i | input | 32 | Level-sensitive interrupt sources |
| psel | input | 1 | Register access select |
| pwrite | input | 1 | Write strobe, qualified by psel |
| paddr | input | 12 | Byte address within the 4 KB window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational, 0 when not reading |
| irq_o | output | 32 | Output lines to the primary controller |

## Verification
A corrupted enable mask shows up at line 31 and in the index 0 readback on the cycle after the write that caused it. A routing bit set outside 21 to 30 shows up in the index 8 readback. A held value lost on a de-routed line shows up on that output line as soon as the source moves. The bench therefore changes each source after every routing change and checks both the output lines and the readback one cycle later.

// File: rtl/sic_pkg.sv
package sic_pkg;
  localparam int REG_MSTAT   = 0;
  localparam int REG_RAW     = 1;
  localparam int REG_EN      = 2;
  localparam int REG_ENCLR   = 3;
  localparam int REG_SOFT    = 4;
  localparam int REG_SOFTCLR = 5;
  localparam int REG_ROUTE   = 8;
  localparam int REG_ROUTECLR = 9;
endpackage

// File: rtl/sic_regs.sv
module sic_regs
  import sic_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int PT_LO = 21,
  parameter int PT_HI = 30,
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [NSRC-1:0]  wdata,
  output logic [NSRC-1:0]  en_q,
  output logic [NSRC-1:0]  route_q
);
  function automatic logic [NSRC-1:0] band_mask();
    logic [NSRC-1:0] m;
    m = '0;
    for (int i = PT_LO; i <= PT_HI; i++) m[i] = 1'b1;
    return m;
  endfunction
  localparam logic [NSRC-1:0] ROUTE_MASK = band_mask();

  logic [NSRC-1:0] en_d, route_d;
  logic            upd;

  always_comb begin
    en_d    = en_q;
    route_d = route_q;
    upd     = 1'b0;
    if (wr_en) begin
      case (idx)
        IDX_W'(REG_EN):       begin en_d = en_q | wdata;  upd = 1'b1; end
        IDX_W'(REG_ENCLR):    begin en_d = en_q & ~wdata; upd = 1'b1; end
        IDX_W'(REG_SOFT):     begin if (|wdata) en_d[0] = 1'b1; upd = 1'b1; end
        IDX_W'(REG_SOFTCLR):  begin if (|wdata) en_d[0] = 1'b0; upd = 1'b1; end
        IDX_W'(REG_ROUTE):    begin route_d = route_q | (wdata & ROUTE_MASK); upd = 1'b1; end
        IDX_W'(REG_ROUTECLR): begin route_d = route_q & ~wdata; upd = 1'b1; end
        default: upd = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      route_q <= '0;
    end else if (upd) begin
      en_q    <= en_d;
      route_q <= route_d;
    end
  end

  AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == IDX_W'(REG_EN)) |=> ((en_q & $past(wdata)) == $past(wdata))); // R3
  AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == IDX_W'(REG_ENCLR)) |=> ((en_q & $past(wdata)) == '0)); // R3
  AST_SOFT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (idx == IDX_W'(REG_SOFT) || idx == IDX_W'(REG_SOFTCLR)) && wdata == '0)
      |=> $stable(en_q)); // R4
  AST_ROUTE_BAND: assert property (@(posedge clk) disable iff (!rst_n)
    (route_q & ~ROUTE_MASK) == '0); // R7
endmodule

// File: rtl/sic_rdmux.sv
module sic_rdmux
  import sic_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int IDX_W = 10
) (
  input  logic             rd_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [NSRC-1:0]  level_q,
  input  logic [NSRC-1:0]  en_q,
  input  logic [NSRC-1:0]  route_q,
  output logic [NSRC-1:0]  rdata
);
  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (idx)
        IDX_W'(REG_MSTAT): rdata = level_q & en_q;
        IDX_W'(REG_RAW):   rdata = level_q;
        IDX_W'(REG_EN):    rdata = en_q;
        IDX_W'(REG_SOFT):  rdata = {{(NSRC-1){1'b0}}, level_q[0]};
        IDX_W'(REG_ROUTE): rdata = route_q;
        default:           rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/sic_outstage.sv
module sic_outstage #(
  parameter int NSRC  = 32,
  parameter int PT_LO = 21,
  parameter int PT_HI = 30,
  parameter int COMB  = 31
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] en_q,
  input  logic [NSRC-1:0] route_q,
  output logic [NSRC-1:0] level_q,
  output logic [NSRC-1:0] irq_o
);
  logic [PT_HI:PT_LO] held_q, held_d;
  logic               held_upd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= src_i;
  end

  always_comb begin
    held_d   = held_q;
    held_upd = |route_q[PT_HI:PT_LO];
    for (int i = PT_LO; i <= PT_HI; i++)
      if (route_q[i]) held_d[i] = level_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        held_q <= '0;
    else if (held_upd) held_q <= held_d;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_line
    if (g == COMB) begin : g_comb
      assign irq_o[g] = |(level_q & en_q);
    end else if (g >= PT_LO && g <= PT_HI) begin : g_route
      assign irq_o[g] = route_q[g] ? level_q[g] : held_q[g];
      AST_HOLD_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (!route_q[g] && !$past(route_q[g])) |-> $stable(irq_o[g])); // R9
    end else begin : g_tie
      assign irq_o[g] = 1'b0;
    end
  end

  AST_LOW_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o[PT_LO-1:0] == '0); // R10
  AST_COMB_FROM_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(src_i & en_q) != '0 && $stable(en_q)) |-> irq_o[COMB]); // R6
endmodule

// File: rtl/sic_pass_ctrl.sv
module sic_pass_ctrl #(
  parameter int NSRC  = 32,
  parameter int AW    = 12,
  parameter int PT_LO = 21,
  parameter int PT_HI = 30
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            psel,
  input  logic            pwrite,
  input  logic [AW-1:0]   paddr,
  input  logic [NSRC-1:0] pwdata,
  output logic [NSRC-1:0] prdata,
  output logic [NSRC-1:0] irq_o
);
  localparam int IDX_W = AW - 2;
  localparam int COMB  = NSRC - 1;

  logic [IDX_W-1:0] idx;
  logic [NSRC-1:0]  en_q, route_q, level_q;
  logic             wr_en, rd_en;
  logic             unused_addr_lsb;

  assign idx             = paddr[AW-1:2];
  assign unused_addr_lsb = ^paddr[1:0];
  assign wr_en           = psel & pwrite;
  assign rd_en           = psel & ~pwrite;

  sic_regs #(.NSRC(NSRC), .PT_LO(PT_LO), .PT_HI(PT_HI), .IDX_W(IDX_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .idx(idx), .wdata(pwdata),
    .en_q(en_q), .route_q(route_q)
  );

  sic_outstage #(.NSRC(NSRC), .PT_LO(PT_LO), .PT_HI(PT_HI), .COMB(COMB)) out_i (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .en_q(en_q), .route_q(route_q),
    .level_q(level_q), .irq_o(irq_o)
  );

  sic_rdmux #(.NSRC(NSRC), .IDX_W(IDX_W)) rd_i (
    .rd_en(rd_en), .idx(idx), .level_q(level_q), .en_q(en_q), .route_q(route_q),
    .rdata(prdata)
  );

  AST_RAW_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && idx == IDX_W'(1)) |-> prdata == $past(src_i)); // R2
  AST_ROUTED_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (route_q[PT_LO] && $stable(route_q[PT_LO])) |-> irq_o[PT_LO] == $past(src_i[PT_LO])); // R8
endmodule

// File: tb/sic_pass_ctrl_tb_top.sv
module sic_pass_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] src_i;
  logic        psel, pwrite;
  logic [11:0] paddr;
  logic [31:0] pwdata, prdata, irq_o;

  always #10 clk = ~clk;

  sic_pass_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .psel(psel), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq_o(irq_o)
  );

  typedef struct {
    bit          on_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];
  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;

  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = sb_q.pop_front();
      act = it.on_irq ? irq_o : prdata;
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic bus_write(input int idx, input logic [31:0] d);
    @(posedge clk); #2;
    psel = 1'b1; pwrite = 1'b1; paddr = 12'(idx * 4); pwdata = d;
    @(posedge clk); #2;
    psel = 1'b0; pwrite = 1'b0;
  endtask

  task automatic expect_rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(posedge clk); #2;
    psel = 1'b1; pwrite = 1'b0; paddr = a;
    sb_q.push_back('{1'b0, e, tag});
    @(negedge clk); #1;
    psel = 1'b0;
  endtask

  task automatic expect_irq(input logic [31:0] e, input string tag);
    @(posedge clk); #2;
    sb_q.push_back('{1'b1, e, tag});
    @(negedge clk); #1;
  endtask

  task automatic set_src(input logic [31:0] v);
    @(posedge clk); #2;
    src_i = v;
    @(posedge clk); #2;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog all-R actual=timeout expected=completion");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; src_i = '0; psel = 1'b0; pwrite = 1'b0; paddr = '0; pwdata = '0;
    repeat (3) @(posedge clk);
    expect_irq(32'h0, "R1 outputs low in reset");
    @(negedge clk); rst_n = 1'b1;
    expect_rd(12'h000, 32'h0, "R1 masked status after reset");
    expect_rd(12'h004, 32'h0, "R1 raw after reset");
    expect_rd(12'h008, 32'h0, "R1 enable after reset");
    expect_rd(12'h020, 32'h0, "R1 routing after reset");

    set_src(32'h0000_00F5);
    expect_rd(12'h004, 32'h0000_00F5, "R2 raw level readback");
    expect_rd(12'h010, 32'h0000_0001, "R4 soft read returns raw bit0");

    bus_write(2, 32'h0000_0F0F);
    expect_rd(12'h008, 32'h0000_0F0F, "R3 enable set");
    expect_rd(12'h000, 32'h0000_0005, "R5 masked status");
    expect_irq(32'h8000_0000, "R6 combined line high");

    bus_write(3, 32'h0000_000F);
    expect_rd(12'h008, 32'h0000_0F00, "R3 enable clear");
    expect_rd(12'h000, 32'h0, "R5 masked status empty");
    expect_irq(32'h0, "R6 combined line low");

    bus_write(4, 32'h0);
    expect_rd(12'h008, 32'h0000_0F00, "R4 zero soft set ignored");
    bus_write(4, 32'h0000_0005);
    expect_rd(12'h008, 32'h0000_0F01, "R4 soft set bit0");
    expect_irq(32'h8000_0000, "R6 soft interrupt raises combined line");
    bus_write(5, 32'h0);
    expect_rd(12'h008, 32'h0000_0F01, "R4 zero soft clear ignored");
    bus_write(5, 32'hFFFF_FFFF);
    expect_rd(12'h008, 32'h0000_0F00, "R4 soft clear bit0 only");

    bus_write(8, 32'hFFFF_FFFF);
    expect_rd(12'h020, 32'h7FE0_0000, "R7 routing set filtered");
    expect_irq(32'h0, "R8 routed lines low with low sources");
    set_src(32'h6060_0001);
    expect_irq(32'h6060_0000, "R8 routed lines follow sources, R10 line0 low");
    bus_write(2, 32'h2000_0000);
    expect_irq(32'hE060_0000, "R6 combined line with routing active");

    bus_write(9, 32'h0060_0000);
    expect_rd(12'h020, 32'h7F80_0000, "R7 routing clear");
    set_src(32'h0000_0000);
    expect_irq(32'h0060_0000, "R9 de-routed lines hold last value");
    set_src(32'h0040_0000);
    expect_irq(32'h0060_0000, "R9 held lines ignore source");
    bus_write(9, 32'hFFFF_FFFF);
    expect_rd(12'h020, 32'h0, "R7 unfiltered clear");

    set_src(32'h001F_FFFF);
    expect_irq(32'h8060_0000, "R10 low lines stay low");

    bus_write(6, 32'hFFFF_FFFF);
    bus_write(32'h3FF, 32'hFFFF_FFFF);
    expect_rd(12'h008, 32'h2000_0F00, "R11 unlisted writes ignored (enable)");
    expect_rd(12'h020, 32'h0, "R11 unlisted writes ignored (routing)");
    expect_rd(12'h018, 32'h0, "R11 unlisted read index 6");
    expect_rd(12'h00C, 32'h0, "R11 write-only index 3 reads 0");
    expect_rd(12'h808, 32'h0, "R11 high address alias reads 0");
    expect_rd(12'hFFC, 32'h0, "R11 last word reads 0");

    repeat (3) @(posedge clk);
    done = 1'b1;
    summary();
  end
endmodule